// File: doc/BRIEF.md
# Multiprocessor Interrupt Steering Controller

This block gathers interrupt requests for a small shared-memory multiprocessor of up to four processors and presents each processor with a 4-bit interrupt level between 0 and 15. There are three kinds of source. Device lines are shared by the whole system. Hardwired lines belong to one processor each. Software interrupts are raised and dropped by writes over the register bus.

Device lines pass through a global mask. Software changes the mask only by writing ones to a set-strobe or a clear-strobe register. A single master bit blocks every device level at once. A fixed table folds the unmasked device lines onto processor levels, and all of those levels go to one processor, chosen by a target register.

Each processor's output is the highest level requested by its own soft bits, its own hardwired lines and, if it is the target, the device levels. Software reads per-processor pending words, the global pending word, the mask and the target through a plain 32-bit register port with one cycle of read latency.

Top module: `irq_steer_ctrl`

## Requirements
- R1: After reset every bit of the global mask reads as 1. All soft interrupts are cleared, the target register reads 0 and every `cpu_pil` field is 0.
- R2: A write to processor c's set word (byte address c*16+8) sets the soft bits where `bus_wdata[31:16]` has ones. A write to its clear word (c*16+4) clears them. Soft level n is read back at bit 16+n of that processor's pending word (c*16+0).
- R3: Bits 15:0 of processor c's pending word return that processor's raw hardwired lines `cpu_hw_irq[c*16 +: 16]`, with bit n standing for level n.
- R4: Writing ones to the mask-set word (0x10C) sets those mask bits. Writing ones to the mask-clear word (0x108) clears them. Other bits are unchanged, and the mask word (0x104) reads back the current mask.
- R5: The global pending word (0x100) reads `dev_irq & ~mask[30:0]` in bits 30:0, and 0 in bit 31. The master bit does not affect this word.
- R6: While mask bit 31 is 1, no device line raises any processor level.
- R7: Each unmasked device line n raises one fixed level:
  - lines 0/7 raise level 2, 1/8 raise 3, 2/9 raise 5 and 3/10 raise 7;
  - lines 4, 11 and 30 raise 9, and lines 5, 12 and 22 raise 11;
  - line 18 raises 4, 16 raises 6, 20 raises 8 and 19 raises 10;
  - lines 14 and 15 raise 12, and line 17 raises 13.
- R8: Device levels reach only the processor whose number is held in the target register (0x110). Writing that register changes the target, and reading it returns the stored number.
- R9: Each `cpu_pil` field equals the highest level from 1 to 15 requested by that processor's soft bits, hardwired lines and routed device levels. It is 0 when none is requested. Requests at level 0 never raise the output.
- R10: `cpu_pil` follows a change on `dev_irq` or `cpu_hw_irq` one clock later. `bus_rdata` returns the word addressed by `bus_addr` one clock later.
- R11: Device lines 6, 13, 21, 28 and 29 show in global pending but raise no level.
- R12: An address outside the processor words and the five global words reads as 0, and a write to it changes no state. Addresses with bits 1:0 nonzero are also unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| dev_irq | input | 31 | Shared device interrupt lines |
| cpu_hw_irq | input | NUM_CPUS*16 | Hardwired per-processor lines, 16 per processor |
| cpu_pil | output | NUM_CPUS*4 | Registered interrupt level, 4 bits per processor |

## Verification
The bench builds the block with its defaults: four processors, a 10-bit address and the global words at 0x100. With four processors, every value of the 2-bit target register names a real processor, so routing to processors 0, 2 and 3 can be observed. The bench also writes into the hole between the processor words and the global words, at an address whose low bits alias processor 0's set word, to show that the write has no effect. Every one of the 31 device lines is raised on its own against the level table.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int WORD_W  = 32;
  localparam int LVL_N   = 16;
  localparam int LVL_W   = 4;
  localparam int DEV_W   = 31;
  localparam int MASTER  = 31;

  // device line positions
  localparam int SRC_MOD_ERR = 30;
  localparam int SRC_FLOPPY  = 22;
  localparam int SRC_VIDEO   = 20;
  localparam int SRC_SYS_TMR = 19;
  localparam int SRC_SCSI    = 18;
  localparam int SRC_AUDIO   = 17;
  localparam int SRC_ENET    = 16;
  localparam int SRC_SERIAL  = 15;
  localparam int SRC_KBD     = 14;
  localparam int SRC_XBUS0   = 7;
  localparam int SRC_BPLANE0 = 0;
  localparam int SLOT_N      = 6;

  typedef enum logic [1:0] {
    C_PEND = 2'd0,
    C_CLR  = 2'd1,
    C_SET  = 2'd2
  } cpu_off_e;

  typedef enum logic [2:0] {
    G_PEND = 3'd0,
    G_MASK = 3'd1,
    G_MCLR = 3'd2,
    G_MSET = 3'd3,
    G_TGT  = 3'd4
  } glb_off_e;

  function automatic int slot_level(input int s);
    case (s)
      0:       return 2;
      1:       return 3;
      2:       return 5;
      3:       return 7;
      4:       return 9;
      default: return 11;
    endcase
  endfunction

  // fold device lines onto processor levels
  function automatic logic [LVL_N-1:0] dev_levels(input logic [DEV_W-1:0] d);
    logic [LVL_N-1:0] l;
    l = '0;
    for (int s = 0; s < SLOT_N; s++) begin
      l[slot_level(s)] = l[slot_level(s)] | d[SRC_XBUS0+s] | d[SRC_BPLANE0+s];
    end
    l[9]  = l[9]  | d[SRC_MOD_ERR];
    l[11] = l[11] | d[SRC_FLOPPY];
    l[4]  = d[SRC_SCSI];
    l[6]  = d[SRC_ENET];
    l[8]  = d[SRC_VIDEO];
    l[10] = d[SRC_SYS_TMR];
    l[12] = d[SRC_SERIAL] | d[SRC_KBD];
    l[13] = d[SRC_AUDIO];
    return l;
  endfunction
endpackage

// File: rtl/irq_glb_regs.sv
module irq_glb_regs
  import irq_steer_pkg::*;
#(
  parameter int TGT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mclr_we,
  input  logic              mset_we,
  input  logic              tgt_we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] mask_q,
  output logic [TGT_W-1:0]  tgt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      tgt_q  <= '0;
    end else begin
      if (mclr_we) mask_q <= mask_q & ~wdata;
      if (mset_we) mask_q <= mask_q | wdata;
      if (tgt_we)  tgt_q  <= wdata[TGT_W-1:0];
    end
  end

  // R4
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    mset_we |=> ((mask_q & $past(wdata)) == $past(wdata)));
  // R4
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    mclr_we |=> ((mask_q & $past(wdata)) == '0));
  // R1
  mask_rst_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '1 && tgt_q == '0));
endmodule

// File: rtl/irq_soft_regs.sv
module irq_soft_regs
  import irq_steer_pkg::*;
#(
  parameter int NUM_CPUS = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_CPUS-1:0]       set_we,
  input  logic [NUM_CPUS-1:0]       clr_we,
  input  logic [LVL_N-1:0]          wbits,
  output logic [NUM_CPUS*LVL_N-1:0] soft_q
);
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [LVL_N-1:0] bits_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        bits_q <= '0;
      end else if (set_we[c]) begin
        bits_q <= bits_q | wbits;
      end else if (clr_we[c]) begin
        bits_q <= bits_q & ~wbits;
      end
    end

    assign soft_q[c*LVL_N +: LVL_N] = bits_q;

    // R2
    soft_set_chk: assert property (@(posedge clk) disable iff (rst)
      set_we[c] |=> ((bits_q & $past(wbits)) == $past(wbits)));
    // R2
    soft_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_we[c] && !set_we[c]) |=> ((bits_q & $past(wbits)) == '0));
  end
endmodule

// File: rtl/irq_lvl_enc.sv
module irq_lvl_enc
  import irq_steer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_N-1:0] req_i,
  output logic [LVL_W-1:0] pil_o
);
  logic [LVL_W-1:0] top_lvl;

  always_comb begin
    top_lvl = '0;
    for (int n = 1; n < LVL_N; n++) begin
      if (req_i[n]) top_lvl = LVL_W'(n);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pil_o <= '0;
    else     pil_o <= top_lvl;
  end

  // R9
  enc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(req_i[LVL_N-1:1]) == '0)) |-> (pil_o == '0));
  // R9
  enc_top_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_i[LVL_N-1])) |-> (pil_o == '1));
endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
  import irq_steer_pkg::*;
#(
  parameter int                NUM_CPUS = 4,
  parameter int                ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] GLB_BASE = 10'h100
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_we,
  input  logic [WORD_W-1:0]         bus_wdata,
  output logic [WORD_W-1:0]         bus_rdata,
  input  logic [DEV_W-1:0]          dev_irq,
  input  logic [NUM_CPUS*LVL_N-1:0] cpu_hw_irq,
  output logic [NUM_CPUS*LVL_W-1:0] cpu_pil
);
  localparam int                TGT_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;
  localparam int                IDX_W    = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] CPU_SPAN = ADDR_W'(NUM_CPUS * 16);

  // address decode
  logic             aligned, cpu_hit, glb_hit;
  logic [IDX_W-1:0] cpu_idx;
  logic [1:0]       cpu_off;
  logic [2:0]       glb_off;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign cpu_hit = aligned && (bus_addr < CPU_SPAN);
  assign glb_hit = aligned && (bus_addr[ADDR_W-1:5] == GLB_BASE[ADDR_W-1:5]);
  assign cpu_idx = bus_addr[ADDR_W-1:4];
  assign cpu_off = bus_addr[3:2];
  assign glb_off = bus_addr[4:2];

  logic [NUM_CPUS-1:0] set_we, clr_we;
  logic                mclr_we, mset_we, tgt_we;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_strobe
    logic own;
    assign own       = bus_we && cpu_hit && (cpu_idx == IDX_W'(c));
    assign set_we[c] = own && (cpu_off == C_SET);
    assign clr_we[c] = own && (cpu_off == C_CLR);
  end

  assign mclr_we = bus_we && glb_hit && (glb_off == G_MCLR);
  assign mset_we = bus_we && glb_hit && (glb_off == G_MSET);
  assign tgt_we  = bus_we && glb_hit && (glb_off == G_TGT);

  logic [WORD_W-1:0]         mask_q;
  logic [TGT_W-1:0]          tgt_q;
  logic [NUM_CPUS*LVL_N-1:0] soft_q;

  irq_glb_regs #(.TGT_W(TGT_W)) u_glb (
    .clk     (clk),
    .rst     (rst),
    .mclr_we (mclr_we),
    .mset_we (mset_we),
    .tgt_we  (tgt_we),
    .wdata   (bus_wdata),
    .mask_q  (mask_q),
    .tgt_q   (tgt_q)
  );

  irq_soft_regs #(.NUM_CPUS(NUM_CPUS)) u_soft (
    .clk    (clk),
    .rst    (rst),
    .set_we (set_we),
    .clr_we (clr_we),
    .wbits  (bus_wdata[WORD_W-1:LVL_N]),
    .soft_q (soft_q)
  );

  // device masking and level folding
  logic [DEV_W-1:0] dev_open;
  logic [LVL_N-1:0] dev_lvl;

  assign dev_open = dev_irq & ~mask_q[DEV_W-1:0];
  assign dev_lvl  = mask_q[MASTER] ? '0 : dev_levels(dev_open);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [LVL_N-1:0] req;
    logic             is_tgt;

    assign is_tgt = (tgt_q == TGT_W'(c));
    assign req    = soft_q[c*LVL_N +: LVL_N] | cpu_hw_irq[c*LVL_N +: LVL_N]
                  | (is_tgt ? dev_lvl : '0);

    irq_lvl_enc u_enc (
      .clk   (clk),
      .rst   (rst),
      .req_i (req),
      .pil_o (cpu_pil[c*LVL_W +: LVL_W])
    );
  end

  // registered read mux
  logic [WORD_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (cpu_hit && (cpu_off == C_PEND)) begin
      for (int c = 0; c < NUM_CPUS; c++) begin
        if (cpu_idx == IDX_W'(c)) begin
          rd_next = {soft_q[c*LVL_N +: LVL_N], cpu_hw_irq[c*LVL_N +: LVL_N]};
        end
      end
    end else if (glb_hit) begin
      case (glb_off)
        G_PEND:  rd_next = {1'b0, dev_open};
        G_MASK:  rd_next = mask_q;
        G_TGT:   rd_next = WORD_W'(tgt_q);
        default: rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // R12
  no_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !cpu_hit && !glb_hit) |=> ($stable(mask_q) && $stable(soft_q) && $stable(tgt_q)));
  // R6
  master_block_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q[MASTER] && (soft_q == '0) && (cpu_hw_irq == '0)) |=> (cpu_pil == '0));
endmodule

// File: tb/irq_steer_ctrl_tb.sv
module irq_steer_ctrl_tb;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [9:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [30:0]   dev_irq = '0;
  logic [NC*16-1:0] cpu_hw_irq = '0;
  logic [NC*4-1:0]  cpu_pil;

  always #10 clk = ~clk;

  irq_steer_ctrl u_dut (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .dev_irq    (dev_irq),
    .cpu_hw_irq (cpu_hw_irq),
    .cpu_pil    (cpu_pil)
  );

  typedef struct {
    int          kind;
    int          cpu;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  item_t cur;
  int    n_cmp = 0;
  int    n_bad = 0;
  logic  arm_req = 1'b0;
  logic  armed_q = 1'b0;
  bit    done = 1'b0;

  always @(posedge clk) armed_q <= arm_req;

  // monitor
  always @(negedge clk) begin
    if (armed_q && q.size() > 0) begin
      logic [31:0] act;
      cur = q.pop_front();
      act = (cur.kind == 0) ? bus_rdata : {28'b0, cpu_pil[cur.cpu*4 +: 4]};
      n_cmp++;
      if (act !== cur.exp) begin
        n_bad++;
        $display("FAIL %s actual=%h expected=%h", cur.tag, act, cur.exp);
      end
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic push_chk(input int kind, input int cpu, input logic [9:0] a,
                          input logic [31:0] e, input string tag);
    item_t it;
    it.kind = kind; it.cpu = cpu; it.exp = e; it.tag = tag;
    @(negedge clk);
    bus_addr = a;
    q.push_back(it);
    arm_req = 1'b1;
    @(negedge clk);
    arm_req = 1'b0;
  endtask

  task automatic rd_chk(input logic [9:0] a, input logic [31:0] e, input string tag);
    push_chk(0, 0, a, e, tag);
  endtask

  task automatic pil_chk(input int cpu, input int e, input string tag);
    push_chk(1, cpu, 10'h3F0, 32'(e), tag);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic direct_chk(input int cpu, input int e, input string tag);
    n_cmp++;
    if (cpu_pil[cpu*4 +: 4] !== 4'(e)) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, cpu_pil[cpu*4 +: 4], e);
    end
  endtask

  function automatic int exp_level(input int s);
    case (s)
      0, 7:       return 2;
      1, 8:       return 3;
      2, 9:       return 5;
      3, 10:      return 7;
      4, 11, 30:  return 9;
      5, 12, 22:  return 11;
      18:         return 4;
      16:         return 6;
      20:         return 8;
      19:         return 10;
      14, 15:     return 12;
      17:         return 13;
      default:    return 0;
    endcase
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      done = 1'b1;
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd_chk(10'h104, 32'hFFFF_FFFF, "R1 mask after reset");
    rd_chk(10'h110, 32'h0, "R1 target after reset");
    rd_chk(10'h000, 32'h0, "R1 cpu0 soft after reset");
    for (int c = 0; c < NC; c++) pil_chk(c, 0, "R1 pil after reset");

    // R2 soft interrupts
    wr(10'h008, 32'h0010_0000);
    settle();
    pil_chk(0, 4, "R2 soft level 4");
    rd_chk(10'h000, 32'h0010_0000, "R2 soft readback");
    wr(10'h008, 32'h0200_0000);
    settle();
    pil_chk(0, 9, "R2 soft level 9 wins");
    wr(10'h004, 32'h0200_0000);
    settle();
    pil_chk(0, 4, "R2 soft clear level 9");
    rd_chk(10'h000, 32'h0010_0000, "R2 after clear");
    wr(10'h004, 32'hFFFF_0000);
    rd_chk(10'h000, 32'h0, "R2 clear all");
    wr(10'h018, 32'h0001_0000);
    settle();
    pil_chk(1, 0, "R9 soft level 0 ignored");
    rd_chk(10'h010, 32'h0001_0000, "R2 cpu1 soft level 0 held");

    // R3 hardwired lines
    @(negedge clk); cpu_hw_irq[2*16 +: 16] = 16'h0400;
    settle();
    pil_chk(2, 10, "R3 hw level 10");
    rd_chk(10'h020, 32'h0000_0400, "R3 hw readback");
    @(negedge clk); cpu_hw_irq[2*16 +: 16] = 16'h0001;
    settle();
    pil_chk(2, 0, "R9 hw level 0 ignored");

    // R4/R5 mask and pending
    wr(10'h108, 32'h8004_0000);
    rd_chk(10'h104, 32'h7FFB_FFFF, "R4 mask clear");
    @(negedge clk); dev_irq = (31'd1 << 18) | (31'd1 << 20);
    settle();
    pil_chk(0, 4, "R7 scsi to level 4");
    rd_chk(10'h100, 32'h0004_0000, "R5 masked pending");

    // R6 master
    wr(10'h10C, 32'h8000_0000);
    settle();
    pil_chk(0, 0, "R6 master blocks");
    rd_chk(10'h104, 32'hFFFB_FFFF, "R4 mask set");
    rd_chk(10'h100, 32'h0004_0000, "R5 pending ignores master");

    // R7/R11 table sweep
    wr(10'h108, 32'hFFFF_FFFF);
    for (int s = 0; s < 31; s++) begin
      @(negedge clk); dev_irq = 31'd1 << s;
      settle();
      pil_chk(0, exp_level(s), $sformatf("R7 R11 line %0d", s));
    end
    rd_chk(10'h100, 32'h4000_0000, "R5 pending line 30");

    // R8 target
    wr(10'h110, 32'h2);
    @(negedge clk); dev_irq = 31'd1 << 19;
    settle();
    pil_chk(2, 10, "R8 routed to cpu2");
    pil_chk(0, 0, "R8 cpu0 not target");
    rd_chk(10'h110, 32'h2, "R8 target readback");

    // R9 priority merge on cpu3
    @(negedge clk); cpu_hw_irq[3*16 +: 16] = 16'h0020; dev_irq = 31'd1 << 17;
    wr(10'h038, 32'h1000_0000);
    wr(10'h110, 32'h3);
    settle();
    pil_chk(3, 13, "R9 device 13 highest");
    pil_chk(2, 0, "R8 cpu2 dropped");
    @(negedge clk); dev_irq = '0;
    settle();
    pil_chk(3, 12, "R9 soft 12 highest");

    // R10 one-cycle latency
    @(negedge clk); cpu_hw_irq[3*16 +: 16] = 16'h8020;
    @(negedge clk);
    direct_chk(3, 15, "R10 pil one clock later");

    // R12 unmapped accesses
    wr(10'h0C8, 32'hFFFF_0000);
    wr(10'h10A, 32'hFFFF_FFFF);
    rd_chk(10'h000, 32'h0, "R12 hole write no alias");
    rd_chk(10'h104, 32'h0, "R12 misaligned write ignored");
    rd_chk(10'h0C0, 32'h0, "R12 hole reads zero");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      finish_run();
    end
  end
endmodule